// File: doc/BRIEF.md
# Load-Use and Branch Stall Cycle Meter

This block sits beside the issue stage of an in-order pipeline that may issue two instructions together as a group. For every issued instruction it is told the instruction's base cost in cycles, up to two source register numbers with valid flags, an optional load destination register, whether the instruction is a branch and whether that branch was taken, and whether the instruction opens and/or closes its issue group. From this it works out the cycles the instruction costs, including penalties. It also keeps running totals for performance analysis.

A load's destination register is recorded in a pending set while its group issues. That set becomes the active load set only when the group's last instruction completes. Any instruction of the following group that reads a register in the active set pays a load-use penalty. A two-instruction group is charged the larger of its two members' costs, not their sum. Load-use and branch penalties are also summed into counters of their own. The block only counts: it does not stall the pipeline, decode instructions or hold register values.

Top module: `issue_stall_meter`

## Requirements
- R1: For each source whose valid flag is set and whose register bit is set in the active load set, 2 cycles are added to the instruction's load stall. Two sources naming the same loaded register add 4.
- R2: A source whose valid flag is clear never adds stall, whatever its register number.
- R3: A load (ld_vld) marks bit ld_reg in the pending set. The pending set is emptied when an instruction with grp_first set arrives. The active set (ld_mask, bit n = register n) is replaced by the pending set when an instruction with grp_last set is accepted. A load is therefore not visible to its own group.
- R4: A branch with br_taken set adds 2 cycles of branch stall and raises taken_count by one. A branch with br_taken clear raises untaken_count by one. A non-branch changes neither count.
- R5: insn_cost shows, from the clock edge that accepts an instruction, its base cycles plus branch stall plus load stall.
- R6: An instruction with grp_last clear stores its cost as the group maximum. An instruction with grp_last set adds the larger of its own cost and that stored maximum to total_cycles. A single instruction has grp_first and grp_last both set, and is charged its own cost.
- R7: ld_stall_cycles and br_stall_cycles accumulate the load and branch stall of every accepted instruction, independently of total_cycles.
- R8: Each counter is CNT_W bits wide (default 32). When an addition would exceed the all-ones value, the counter holds at all-ones.
- R9: An active-low reset clears all counters, insn_cost, ld_mask and the internal pending set and group maximum.
- R10: While insn_vld is low, no output or internal state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_vld | input | 1 | An instruction is issued this cycle |
| grp_first | input | 1 | Instruction opens its issue group |
| grp_last | input | 1 | Instruction closes its issue group |
| base_cyc | input | BASE_W | Base cycle cost of the instruction |
| src0_vld | input | 1 | First source register is used |
| src0_reg | input | REG_W | First source register number |
| src1_vld | input | 1 | Second source register is used |
| src1_reg | input | REG_W | Second source register number |
| ld_vld | input | 1 | Instruction is a load |
| ld_reg | input | REG_W | Load destination register number |
| br_vld | input | 1 | Instruction is a branch |
| br_taken | input | 1 | Branch was taken |
| insn_cost | output | COST_W | Cost of the most recently accepted instruction |
| ld_mask | output | NREG | Active load set |
| total_cycles | output | CNT_W | Accumulated group-charged cycles |
| ld_stall_cycles | output | CNT_W | Accumulated load-use stall cycles |
| br_stall_cycles | output | CNT_W | Accumulated branch stall cycles |
| taken_count | output | CNT_W | Taken branch count |
| untaken_count | output | CNT_W | Not-taken branch count |

## Verification
The assertions assume a well-formed group protocol. Every group opens with grp_first and closes with grp_last, holds at most two instructions, and carries meaningful fields whenever insn_vld is high. The stimulus only issues singles with both flags set, or pairs whose first member has only grp_first set and whose second member has only grp_last set. It also never lets a counter approach its limit except in the dedicated saturation run. Idle cycles deliberately carry busy-looking field values, so a missing insn_vld qualification shows up at the ports.

// File: rtl/issue_stall_meter_pkg.sv
package issue_stall_meter_pkg;
  // Penalties charged per hazard
  localparam int unsigned LOAD_PENALTY   = 2;
  localparam int unsigned BRANCH_PENALTY = 2;
  // Number of source operands looked up per instruction
  localparam int unsigned NUM_SRC        = 2;
  // Extra bits of headroom above the base cost width
  localparam int unsigned COST_PAD       = 4;
endpackage

// File: rtl/ism_hazard_detect.sv
module ism_hazard_detect #(
  parameter int unsigned NREG  = 16,
  parameter int unsigned NSRC  = 2,
  localparam int unsigned REG_W = $clog2(NREG),
  localparam int unsigned HIT_W = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]       src_vld,
  input  logic [NSRC*REG_W-1:0] src_reg,
  input  logic [NREG-1:0]       load_set,
  output logic [HIT_W-1:0]      hit_count
);
  logic [NSRC-1:0] hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [REG_W-1:0] idx;
    assign idx    = src_reg[s*REG_W +: REG_W];
    assign hit[s] = src_vld[s] & load_set[idx];
  end

  always_comb begin
    hit_count = '0;
    for (int s = 0; s < NSRC; s++) begin
      hit_count = hit_count + HIT_W'(hit[s]);
    end
  end
endmodule

// File: rtl/ism_sat_counter.sv
module ism_sat_counter #(
  parameter int unsigned W     = 32,
  parameter int unsigned INC_W = 8,
  localparam int unsigned SW   = W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     count
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [SW-1:0] sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + SW'(inc);
    cnt_d = sum[W] ? {W{1'b1}} : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/ism_group_tracker.sv
module ism_group_tracker #(
  parameter int unsigned NREG   = 16,
  parameter int unsigned COST_W = 12,
  localparam int unsigned REG_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_vld,
  input  logic              grp_first,
  input  logic              grp_last,
  input  logic              ld_vld,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [COST_W-1:0] cost,
  output logic [NREG-1:0]   active_set,
  output logic [COST_W-1:0] group_charge
);
  logic [NREG-1:0]   pend_q, pend_d, active_q;
  logic [COST_W-1:0] peak_q, peak_base;
  logic [NREG-1:0]   ld_onehot;

  always_comb begin
    ld_onehot = {{(NREG-1){1'b0}}, 1'b1} << ld_reg;
    pend_d    = grp_first ? '0 : pend_q;
    if (ld_vld) pend_d = pend_d | ld_onehot;
    peak_base    = grp_first ? '0 : peak_q;
    group_charge = (cost > peak_base) ? cost : peak_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      peak_q   <= '0;
      active_q <= '0;
    end else if (insn_vld) begin
      pend_q <= pend_d;
      if (grp_last) active_q <= pend_d;
      else          peak_q   <= cost;
    end
  end

  assign active_set = active_q;
endmodule

// File: rtl/issue_stall_meter.sv
module issue_stall_meter
  import issue_stall_meter_pkg::*;
#(
  parameter int unsigned NREG   = 16,
  parameter int unsigned BASE_W = 8,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned REG_W  = $clog2(NREG),
  localparam int unsigned COST_W = BASE_W + COST_PAD,
  localparam int unsigned HIT_W  = $clog2(NUM_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_vld,
  input  logic              grp_first,
  input  logic              grp_last,
  input  logic [BASE_W-1:0] base_cyc,
  input  logic              src0_vld,
  input  logic [REG_W-1:0]  src0_reg,
  input  logic              src1_vld,
  input  logic [REG_W-1:0]  src1_reg,
  input  logic              ld_vld,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic              br_vld,
  input  logic              br_taken,
  output logic [COST_W-1:0] insn_cost,
  output logic [NREG-1:0]   ld_mask,
  output logic [CNT_W-1:0]  total_cycles,
  output logic [CNT_W-1:0]  ld_stall_cycles,
  output logic [CNT_W-1:0]  br_stall_cycles,
  output logic [CNT_W-1:0]  taken_count,
  output logic [CNT_W-1:0]  untaken_count
);
  logic [HIT_W-1:0]  hits;
  logic [COST_W-1:0] ld_pen, br_pen, cost_d, cost_q, charge;
  logic [NREG-1:0]   active_set;
  logic              is_taken, is_untaken;

  ism_hazard_detect #(.NREG(NREG), .NSRC(NUM_SRC)) u_hazard (
    .src_vld   ({src1_vld, src0_vld}),
    .src_reg   ({src1_reg, src0_reg}),
    .load_set  (active_set),
    .hit_count (hits)
  );

  always_comb begin
    is_taken   = br_vld & br_taken;
    is_untaken = br_vld & ~br_taken;
    ld_pen     = COST_W'(hits) * COST_W'(LOAD_PENALTY);
    br_pen     = is_taken ? COST_W'(BRANCH_PENALTY) : '0;
    cost_d     = COST_W'(base_cyc) + br_pen + ld_pen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_q <= '0;
    end else if (insn_vld) begin
      cost_q <= cost_d;
    end
  end

  ism_group_tracker #(.NREG(NREG), .COST_W(COST_W)) u_group (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_vld     (insn_vld),
    .grp_first    (grp_first),
    .grp_last     (grp_last),
    .ld_vld       (ld_vld),
    .ld_reg       (ld_reg),
    .cost         (cost_d),
    .active_set   (active_set),
    .group_charge (charge)
  );

  ism_sat_counter #(.W(CNT_W), .INC_W(COST_W)) u_cnt_total (
    .clk (clk), .rst_n (rst_n), .en (insn_vld & grp_last),
    .inc (charge), .count (total_cycles)
  );

  ism_sat_counter #(.W(CNT_W), .INC_W(COST_W)) u_cnt_ld (
    .clk (clk), .rst_n (rst_n), .en (insn_vld & (hits != '0)),
    .inc (ld_pen), .count (ld_stall_cycles)
  );

  ism_sat_counter #(.W(CNT_W), .INC_W(COST_W)) u_cnt_br (
    .clk (clk), .rst_n (rst_n), .en (insn_vld & is_taken),
    .inc (br_pen), .count (br_stall_cycles)
  );

  ism_sat_counter #(.W(CNT_W), .INC_W(1)) u_cnt_taken (
    .clk (clk), .rst_n (rst_n), .en (insn_vld & is_taken),
    .inc (1'b1), .count (taken_count)
  );

  ism_sat_counter #(.W(CNT_W), .INC_W(1)) u_cnt_untaken (
    .clk (clk), .rst_n (rst_n), .en (insn_vld & is_untaken),
    .inc (1'b1), .count (untaken_count)
  );

  assign insn_cost = cost_q;
  assign ld_mask   = active_set;
endmodule

// File: rtl/issue_stall_meter_chk.sv
module issue_stall_meter_chk #(
  parameter int unsigned NREG   = 16,
  parameter int unsigned BASE_W = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned COST_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_vld,
  input logic              grp_last,
  input logic [BASE_W-1:0] base_cyc,
  input logic              src0_vld,
  input logic              src1_vld,
  input logic              br_vld,
  input logic              br_taken,
  input logic [COST_W-1:0] insn_cost,
  input logic [NREG-1:0]   ld_mask,
  input logic [CNT_W-1:0]  total_cycles,
  input logic [CNT_W-1:0]  taken_count
);
  // R2
  plain_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && !src0_vld && !src1_vld && !(br_vld && br_taken))
      |=> insn_cost == COST_W'($past(base_cyc)));

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(insn_vld && grp_last) |=> $stable(ld_mask));

  // R4
  taken_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && br_vld && br_taken && taken_count != {CNT_W{1'b1}})
      |=> taken_count == $past(taken_count) + 1'b1);

  // R8
  total_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total_cycles >= $past(total_cycles));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_vld |=> ($stable(total_cycles) && $stable(insn_cost) && $stable(taken_count)));
endmodule

bind issue_stall_meter issue_stall_meter_chk #(
  .NREG(NREG), .BASE_W(BASE_W), .CNT_W(CNT_W), .COST_W(COST_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .insn_vld     (insn_vld),
  .grp_last     (grp_last),
  .base_cyc     (base_cyc),
  .src0_vld     (src0_vld),
  .src1_vld     (src1_vld),
  .br_vld       (br_vld),
  .br_taken     (br_taken),
  .insn_cost    (insn_cost),
  .ld_mask      (ld_mask),
  .total_cycles (total_cycles),
  .taken_count  (taken_count)
);

// File: tb/test_issue_stall_meter.sv
`timescale 1ns/1ps
module test_issue_stall_meter;
  localparam int unsigned CW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic insn_vld, grp_first, grp_last, src0_vld, src1_vld, ld_vld, br_vld, br_taken;
  logic [7:0]  base_cyc;
  logic [3:0]  src0_reg, src1_reg, ld_reg;
  logic [11:0] insn_cost;
  logic [15:0] ld_mask;
  logic [CW-1:0] total_cycles, ld_stall_cycles, br_stall_cycles, taken_count, untaken_count;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  issue_stall_meter #(.NREG(16), .BASE_W(8), .CNT_W(CW)) i_issue_stall_meter (
    .clk (clk), .rst_n (rst_n), .insn_vld (insn_vld),
    .grp_first (grp_first), .grp_last (grp_last), .base_cyc (base_cyc),
    .src0_vld (src0_vld), .src0_reg (src0_reg),
    .src1_vld (src1_vld), .src1_reg (src1_reg),
    .ld_vld (ld_vld), .ld_reg (ld_reg), .br_vld (br_vld), .br_taken (br_taken),
    .insn_cost (insn_cost), .ld_mask (ld_mask),
    .total_cycles (total_cycles), .ld_stall_cycles (ld_stall_cycles),
    .br_stall_cycles (br_stall_cycles), .taken_count (taken_count),
    .untaken_count (untaken_count)
  );

  typedef struct packed {
    logic f, l; logic [7:0] base;
    logic av; logic [3:0] a; logic bv; logic [3:0] b;
    logic lv; logic [3:0] d; logic brv, tk;
    logic [11:0] cost; logic [15:0] mask;
  } vec_t;

  // f l base | av a bv b | lv d | brv tk | cost mask
  localparam vec_t VEC [11] = '{
    '{1'b1,1'b1,8'd3, 1'b0,4'd0,1'b0,4'd0, 1'b1,4'd5, 1'b0,1'b0, 12'd3,16'h0020}, // R3 load marks r5
    '{1'b1,1'b1,8'd1, 1'b1,4'd5,1'b0,4'd0, 1'b0,4'd0, 1'b0,1'b0, 12'd3,16'h0000}, // R1 hit
    '{1'b1,1'b1,8'd2, 1'b1,4'd5,1'b0,4'd0, 1'b0,4'd0, 1'b0,1'b0, 12'd2,16'h0000}, // R3 one group only
    '{1'b1,1'b0,8'd4, 1'b0,4'd0,1'b0,4'd0, 1'b1,4'd3, 1'b1,1'b1, 12'd6,16'h0000}, // R4 taken, R6 first
    '{1'b0,1'b1,8'd1, 1'b1,4'd3,1'b0,4'd0, 1'b1,4'd7, 1'b0,1'b0, 12'd1,16'h0088}, // R3 not in own group
    '{1'b1,1'b1,8'd1, 1'b1,4'd3,1'b1,4'd7, 1'b1,4'd9, 1'b0,1'b0, 12'd5,16'h0200}, // R1 two hits
    '{1'b1,1'b1,8'd2, 1'b0,4'd9,1'b0,4'd9, 1'b0,4'd0, 1'b1,1'b0, 12'd2,16'h0000}, // R2, R4 untaken
    '{1'b1,1'b0,8'd1, 1'b0,4'd0,1'b0,4'd0, 1'b0,4'd0, 1'b1,1'b1, 12'd3,16'h0000}, // R6 cheaper first
    '{1'b0,1'b1,8'd5, 1'b0,4'd0,1'b0,4'd0, 1'b0,4'd0, 1'b0,1'b0, 12'd5,16'h0000}, // R6 last larger
    '{1'b1,1'b1,8'd1, 1'b0,4'd0,1'b0,4'd0, 1'b1,4'd0, 1'b0,1'b0, 12'd1,16'h0001}, // R3 r0
    '{1'b1,1'b1,8'd1, 1'b1,4'd0,1'b1,4'd0, 1'b0,4'd0, 1'b0,1'b0, 12'd5,16'h0000}  // R1 same reg twice
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    insn_vld = vld; grp_first = v.f; grp_last = v.l; base_cyc = v.base;
    src0_vld = v.av; src0_reg = v.a; src1_vld = v.bv; src1_reg = v.b;
    ld_vld = v.lv; ld_reg = v.d; br_vld = v.brv; br_taken = v.tk;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    vec_t busy;
    busy = '{1'b1,1'b1,8'd255, 1'b1,4'd0,1'b1,4'd0, 1'b1,4'd4, 1'b1,1'b1, 12'd0,16'h0};
    rst_n = 1'b0;
    drive('0, 1'b0);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 insn_cost", 32'(insn_cost), 0);
    check("R9 ld_mask", 32'(ld_mask), 0);
    check("R9 total_cycles", 32'(total_cycles), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      drive(VEC[i], 1'b1);
      @(negedge clk);
      check($sformatf("R5 cost vec%0d", i), 32'(insn_cost), 32'(VEC[i].cost));
      check($sformatf("R3 mask vec%0d", i), 32'(ld_mask), 32'(VEC[i].mask));
    end
    drive('0, 1'b0);
    check("R6 total_cycles", 32'(total_cycles), 32);
    check("R7 ld_stall_cycles", 32'(ld_stall_cycles), 10);
    check("R7 br_stall_cycles", 32'(br_stall_cycles), 4);
    check("R4 taken_count", 32'(taken_count), 2);
    check("R4 untaken_count", 32'(untaken_count), 1);

    // R10 idle cycles with busy-looking fields
    drive(busy, 1'b0);
    repeat (3) @(negedge clk);
    check("R10 total_cycles", 32'(total_cycles), 32);
    check("R10 taken_count", 32'(taken_count), 2);
    check("R10 insn_cost", 32'(insn_cost), 5);
    check("R10 ld_mask", 32'(ld_mask), 0);

    // R9 reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 total after reset", 32'(total_cycles), 0);
    check("R9 ld_stall after reset", 32'(ld_stall_cycles), 0);
    check("R9 untaken after reset", 32'(untaken_count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 saturation: singles of base 255, no penalties
    busy = '{1'b1,1'b1,8'd255, 1'b0,4'd0,1'b0,4'd0, 1'b0,4'd0, 1'b0,1'b0, 12'd0,16'h0};
    drive(busy, 1'b1);
    repeat (4) @(negedge clk);
    check("R8 below limit", 32'(total_cycles), 1020);
    @(negedge clk);
    check("R8 saturated", 32'(total_cycles), 1023);
    @(negedge clk);
    check("R8 held", 32'(total_cycles), 1023);
    drive('0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule